// File: doc/BRIEF.md
# TPM Data-FIFO Command/Response Sequencer

This block carries one complete command/response exchange with a TPM over its data FIFO. A command packet already sits in a local byte buffer. On `start`, the block first checks that the length field inside the packet agrees with the length it was given. It then tells the device to get ready for a command. It pushes the packet out in pieces, each no larger than the device currently accepts, and releases the command for execution. It then polls the status register until a reply is waiting. The reply is pulled into a second local buffer, and the status flags are checked around the final byte.

Every register access goes through an external transaction framer over a simple request/byte port. The sequencer names the target (status register or data FIFO), the direction and the byte count from 1 to 64. It then supplies or collects one byte per framer beat and waits for the framer's completion pulse. The status register travels least significant byte first. In that word, bits 23:8 give the burst count, bit 7 means valid, bit 6 is the command-ready request, bit 5 is the go request and bit 4 means data available.

Top module: `tpm_fifo_seq`

## Requirements
- R1: A `start` while `initialized` is low ends on the next cycle with `done`, error code 1 and `rsp_len` 0, and no framer transaction is issued.
- R2: The command buffer's bytes 2..5, read as a big-endian 32-bit number, must equal `cmd_len`, and `cmd_len` must be at least 6. If not, the run ends with error code 2 and no transaction is issued.
- R3: The first transaction is a 4-byte status write of 0x00000040 (command-ready). A 4-byte status write of 0x00000020 (go) follows the last command byte. A successful run ends with another 4-byte status write of 0x00000040. The framer request and its fields stay stable until the completion pulse.
- R4: Every data-FIFO chunk, in either direction, is preceded by a 4-byte status read. While the burst count read there is zero, the read is repeated and the FIFO is not touched.
- R5: Each chunk's byte count is the smallest of the bytes still to move, the last burst count and 64. The command bytes reach the FIFO unchanged and in buffer order.
- R6: After go, and again after each poll that is not ready, the block waits at least POLL_GAP idle cycles before the next status read. It moves on once bits 7 and 4 are both set. If MAX_POLLS reads come back not ready, the run ends with error code 3 and nothing more is issued.
- R7: The first response access is a 6-byte FIFO read, and its bytes 2..5 (big-endian) give the response length. A length above `rsp_max` ends the run with error code 4. A length below 7 ends it with error code 5.
- R8: Response bytes land in the response buffer at offsets 0 upward, in arrival order. After all but the last byte, a status read must show bits 7 and 4 both set, or the run ends with error code 6.
- R9: The last response byte is fetched in a 1-byte FIFO read. The status read that follows must show bit 7 set and bit 4 clear, or the run ends with error code 7. A 7-byte response moves no chunk between the header and this byte.
- R10: Each run ends with a one-cycle `done` pulse. On success the error code is 0 and `rsp_len` equals the response length. On any error `rsp_len` is 0.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an exchange (sampled while idle) |
| initialized | input | 1 | Device has been probed and is usable |
| cmd_len | input | AW+1 | Supplied command length in bytes |
| rsp_max | input | AW+1 | Response buffer capacity in bytes |
| cmd_addr | output | AW | Command buffer read address |
| cmd_data | input | 8 | Command buffer byte at `cmd_addr`, same cycle |
| rsp_we | output | 1 | Response buffer write strobe |
| rsp_addr | output | AW | Response buffer write address |
| rsp_wdata | output | 8 | Response buffer write byte |
| txn_req | output | 1 | Framer transaction request, held until `txn_done` |
| txn_write | output | 1 | 1 = write to device, 0 = read |
| txn_fifo | output | 1 | 1 = data FIFO, 0 = status register |
| txn_len | output | clog2(MAX_CHUNK+1) | Transaction byte count |
| txn_wbyte | output | 8 | Byte offered to the framer on a write |
| txn_take | input | 1 | Framer consumed `txn_wbyte` |
| txn_rbyte | input | 8 | Byte delivered by the framer on a read |
| txn_rvalid | input | 1 | `txn_rbyte` is valid |
| txn_done | input | 1 | Transaction complete (after its last byte beat) |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rsp_len | output | AW+1 | Response length, 0 on error |
| err_code | output | 3 | 0 ok, 1..7 per requirements |

## Verification
The hardest paths to reach are the status checks around the final response byte and the zero-burst stall. Both depend on the device answering status reads with particular words at particular points in the run. The bench plays the device. Each expected transaction is queued together with the status word to hand back for it, so a script can stall with zero bursts, hold back readiness for a set number of polls, or report wrong flags just before or just after the last byte. The poll spacing is measured in cycles between the framer's completion of one access and the next request.

// File: rtl/tpmseq_pkg.sv
package tpmseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_LEN, S_CRDY1, S_BURST, S_XFER, S_GO, S_WAIT,
        S_POLL, S_HDR, S_MID, S_LAST, S_END, S_CRDY2, S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        E_OK      = 3'd0,
        E_NOINIT  = 3'd1,
        E_CMDLEN  = 3'd2,
        E_TIMEOUT = 3'd3,
        E_TOOBIG  = 3'd4,
        E_SHORT   = 3'd5,
        E_MIDSTS  = 3'd6,
        E_ENDSTS  = 3'd7
    } seq_err_e;

    localparam logic [31:0] STS_WORD_READY = 32'h0000_0040;
    localparam logic [31:0] STS_WORD_GO    = 32'h0000_0020;
    localparam int          STS_BYTES      = 4;
    localparam int          HDR_BYTES      = 6;
    localparam int          BURST_LSB      = 8;
    localparam int          BURST_W        = 16;
    localparam int          VALID_BIT      = 7;
    localparam int          AVAIL_BIT      = 4;

endpackage

// File: rtl/tpmseq_stsdec.sv
module tpmseq_stsdec
    import tpmseq_pkg::*;
(
    input  logic [31:0]        sts,
    output logic [BURST_W-1:0] burst,
    output logic               ready_both,
    output logic               drained
);
    logic valid_b;
    logic avail_b;

    always_comb begin
        burst      = sts[BURST_LSB +: BURST_W];
        valid_b    = sts[VALID_BIT];
        avail_b    = sts[AVAIL_BIT];
        ready_both = valid_b & avail_b;
        drained    = valid_b & ~avail_b;
    end
endmodule

// File: rtl/tpmseq_chunk.sv
module tpmseq_chunk #(
    parameter int REM_W     = 9,
    parameter int BURST_W   = 16,
    parameter int MAX_CHUNK = 64,
    localparam int CW       = $clog2(MAX_CHUNK + 1)
) (
    input  logic [REM_W-1:0]   remain,
    input  logic [BURST_W-1:0] burst,
    output logic [CW-1:0]      chunk
);
    logic [31:0] m;

    always_comb begin
        m = 32'(remain);
        if (32'(burst) < m)
            m = 32'(burst);
        if (32'(MAX_CHUNK) < m)
            m = 32'(MAX_CHUNK);
        chunk = CW'(m);
    end
endmodule

// File: rtl/tpm_fifo_seq.sv
module tpm_fifo_seq
    import tpmseq_pkg::*;
#(
    parameter int AW        = 8,
    parameter int MAX_CHUNK = 64,
    parameter int POLL_GAP  = 100000,
    parameter int MAX_POLLS = 120000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             initialized,
    input  logic [AW:0]                      cmd_len,
    input  logic [AW:0]                      rsp_max,
    output logic [AW-1:0]                    cmd_addr,
    input  logic [7:0]                       cmd_data,
    output logic                             rsp_we,
    output logic [AW-1:0]                    rsp_addr,
    output logic [7:0]                       rsp_wdata,
    output logic                             txn_req,
    output logic                             txn_write,
    output logic                             txn_fifo,
    output logic [$clog2(MAX_CHUNK+1)-1:0]   txn_len,
    output logic [7:0]                       txn_wbyte,
    input  logic                             txn_take,
    input  logic [7:0]                       txn_rbyte,
    input  logic                             txn_rvalid,
    input  logic                             txn_done,
    output logic                             busy,
    output logic                             done,
    output logic [AW:0]                      rsp_len,
    output logic [2:0]                       err_code
);
    localparam int CW     = $clog2(MAX_CHUNK + 1);
    localparam int RW     = AW + 1;
    localparam int GAP_W  = $clog2(POLL_GAP + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        seq_state_e        st;
        logic              rx;
        logic [RW-1:0]     ptr;
        logic [RW-1:0]     remain;
        logic [CW-1:0]     idx;
        logic [CW-1:0]     chunk;
        logic [31:0]       sts;
        logic [31:0]       plen;
        logic [GAP_W-1:0]  gap;
        logic [POLL_W-1:0] polls;
        logic [RW-1:0]     rlen;
        logic [2:0]        err;
    } seq_t;

    seq_t q, n;

    logic [BURST_W-1:0] burst;
    logic               ready_both;
    logic               drained;
    logic [CW-1:0]      chunk_sz;
    logic               beat;
    logic               sts_rd;
    logic               fifo_acc;
    logic [31:0]        enc_len;

    tpmseq_stsdec u_dec (
        .sts        (q.sts),
        .burst      (burst),
        .ready_both (ready_both),
        .drained    (drained)
    );

    tpmseq_chunk #(
        .REM_W     (RW),
        .BURST_W   (BURST_W),
        .MAX_CHUNK (MAX_CHUNK)
    ) u_chunk (
        .remain (q.remain),
        .burst  (burst),
        .chunk  (chunk_sz)
    );

    function automatic logic [7:0] word_byte(logic [31:0] w, logic [1:0] i);
        return w[i*8 +: 8];
    endfunction

    // transaction and buffer-port drive, decoded from the present state
    always_comb begin
        txn_req   = 1'b0;
        txn_write = 1'b0;
        txn_fifo  = 1'b0;
        txn_len   = CW'(STS_BYTES);
        txn_wbyte = 8'h00;
        cmd_addr  = q.ptr[AW-1:0];
        rsp_we    = 1'b0;
        case (q.st)
            S_LEN: cmd_addr = AW'(2) + AW'(q.idx);
            S_CRDY1, S_CRDY2: begin
                txn_req   = 1'b1;
                txn_write = 1'b1;
                txn_wbyte = word_byte(STS_WORD_READY, q.idx[1:0]);
            end
            S_GO: begin
                txn_req   = 1'b1;
                txn_write = 1'b1;
                txn_wbyte = word_byte(STS_WORD_GO, q.idx[1:0]);
            end
            S_BURST, S_POLL, S_MID, S_END: txn_req = 1'b1;
            S_XFER: begin
                txn_req   = 1'b1;
                txn_fifo  = 1'b1;
                txn_write = ~q.rx;
                txn_len   = q.chunk;
                txn_wbyte = cmd_data;
                rsp_we    = q.rx & txn_rvalid;
            end
            S_HDR: begin
                txn_req  = 1'b1;
                txn_fifo = 1'b1;
                txn_len  = CW'(HDR_BYTES);
                rsp_we   = txn_rvalid;
            end
            S_LAST: begin
                txn_req  = 1'b1;
                txn_fifo = 1'b1;
                txn_len  = CW'(1);
                rsp_we   = txn_rvalid;
            end
            default: ;
        endcase
        rsp_addr  = q.ptr[AW-1:0];
        rsp_wdata = txn_rbyte;
    end

    // next-state computation
    always_comb begin
        n        = q;
        beat     = txn_take | txn_rvalid;
        sts_rd   = (q.st == S_BURST) || (q.st == S_POLL) || (q.st == S_MID) || (q.st == S_END);
        fifo_acc = (q.st == S_XFER) || (q.st == S_HDR) || (q.st == S_LAST);
        enc_len  = {q.plen[23:0], cmd_data};
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    n.err  = E_OK;
                    n.rlen = '0;
                    n.idx  = '0;
                    n.plen = '0;
                    n.rx   = 1'b0;
                    if (!initialized) begin
                        n.err = E_NOINIT;
                        n.st  = S_DONE;
                    end else begin
                        n.st = S_LEN;
                    end
                end
            end
            S_LEN: begin
                n.plen = enc_len;
                n.idx  = q.idx + CW'(1);
                if (q.idx == CW'(3)) begin
                    n.idx = '0;
                    if ((enc_len != 32'(cmd_len)) || (cmd_len < RW'(HDR_BYTES))) begin
                        n.err = E_CMDLEN;
                        n.st  = S_DONE;
                    end else begin
                        n.st = S_CRDY1;
                    end
                end
            end
            S_WAIT: begin
                n.gap = q.gap + GAP_W'(1);
                if (q.gap == GAP_W'(POLL_GAP - 1)) begin
                    n.gap = '0;
                    n.st  = S_POLL;
                end
            end
            S_DONE: n.st = S_IDLE;
            default: begin
                if (beat) begin
                    n.idx = q.idx + CW'(1);
                    if (sts_rd)
                        n.sts[q.idx[1:0]*8 +: 8] = txn_rbyte;
                    if (fifo_acc)
                        n.ptr = q.ptr + RW'(1);
                    if ((q.st == S_HDR) && (q.idx >= CW'(2)))
                        n.plen = {q.plen[23:0], txn_rbyte};
                end
                if (txn_done) begin
                    n.idx = '0;
                    case (q.st)
                        S_CRDY1: begin
                            n.st     = S_BURST;
                            n.rx     = 1'b0;
                            n.ptr    = '0;
                            n.remain = cmd_len;
                        end
                        S_BURST: begin
                            if (burst != '0) begin
                                n.chunk = chunk_sz;
                                n.st    = S_XFER;
                            end
                        end
                        S_XFER: begin
                            n.remain = q.remain - RW'(q.chunk);
                            if (q.remain == RW'(q.chunk))
                                n.st = q.rx ? S_MID : S_GO;
                            else
                                n.st = S_BURST;
                        end
                        S_GO: begin
                            n.st    = S_WAIT;
                            n.gap   = '0;
                            n.polls = '0;
                        end
                        S_POLL: begin
                            if (ready_both) begin
                                n.st   = S_HDR;
                                n.ptr  = '0;
                                n.plen = '0;
                            end else if (q.polls == POLL_W'(MAX_POLLS - 1)) begin
                                n.err = E_TIMEOUT;
                                n.st  = S_DONE;
                            end else begin
                                n.polls = q.polls + POLL_W'(1);
                                n.st    = S_WAIT;
                            end
                        end
                        S_HDR: begin
                            n.rx     = 1'b1;
                            n.remain = RW'(q.plen - 32'd7);
                            if (q.plen > 32'(rsp_max)) begin
                                n.err = E_TOOBIG;
                                n.st  = S_DONE;
                            end else if (q.plen < 32'd7) begin
                                n.err = E_SHORT;
                                n.st  = S_DONE;
                            end else if (q.plen == 32'd7) begin
                                n.st = S_MID;
                            end else begin
                                n.st = S_BURST;
                            end
                        end
                        S_MID: begin
                            if (ready_both)
                                n.st = S_LAST;
                            else begin
                                n.err = E_MIDSTS;
                                n.st  = S_DONE;
                            end
                        end
                        S_LAST: n.st = S_END;
                        S_END: begin
                            if (drained)
                                n.st = S_CRDY2;
                            else begin
                                n.err = E_ENDSTS;
                                n.st  = S_DONE;
                            end
                        end
                        S_CRDY2: begin
                            n.rlen = RW'(q.plen);
                            n.st   = S_DONE;
                        end
                        default: n.st = S_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= n;
    end

    assign busy     = (q.st != S_IDLE);
    assign done     = (q.st == S_DONE);
    assign rsp_len  = q.rlen;
    assign err_code = q.err;

endmodule

// File: rtl/tpmseq_chk.sv
module tpmseq_chk #(
    parameter int AW        = 8,
    parameter int MAX_CHUNK = 64,
    localparam int CW       = $clog2(MAX_CHUNK + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          initialized,
    input logic [AW:0]   rsp_max,
    input logic          rsp_we,
    input logic [AW-1:0] rsp_addr,
    input logic          txn_req,
    input logic          txn_write,
    input logic          txn_fifo,
    input logic [CW-1:0] txn_len,
    input logic          txn_done,
    input logic          busy,
    input logic          done,
    input logic [AW:0]   rsp_len,
    input logic [2:0]    err_code
);
    // R5
    chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_req |-> (txn_len != '0) && (32'(txn_len) <= MAX_CHUNK));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !txn_done) |=> (txn_req && $stable(txn_len) && $stable(txn_fifo) && $stable(txn_write)));

    // R10
    err_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (err_code != 3'd0)) |-> (rsp_len == '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    noinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !initialized) |=> (done && (err_code == 3'd1)));

    // R8
    rsp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_we |-> ({1'b0, rsp_addr} < rsp_max));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !txn_req);
endmodule

bind tpm_fifo_seq tpmseq_chk #(.AW(AW), .MAX_CHUNK(MAX_CHUNK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .initialized (initialized),
    .rsp_max     (rsp_max),
    .rsp_we      (rsp_we),
    .rsp_addr    (rsp_addr),
    .txn_req     (txn_req),
    .txn_write   (txn_write),
    .txn_fifo    (txn_fifo),
    .txn_len     (txn_len),
    .txn_done    (txn_done),
    .busy        (busy),
    .done        (done),
    .rsp_len     (rsp_len),
    .err_code    (err_code)
);

// File: tb/sim_tpm_fifo_seq.sv
module sim_tpm_fifo_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int MAXC       = 64;
    localparam int GAP        = 4;
    localparam int MPOLL      = 5;
    localparam int CW         = $clog2(MAXC + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          initialized = 1'b0;
    logic [AW:0]   cmd_len = '0;
    logic [AW:0]   rsp_max = '0;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;
    logic          rsp_we;
    logic [AW-1:0] rsp_addr;
    logic [7:0]    rsp_wdata;
    logic          txn_req, txn_write, txn_fifo;
    logic [CW-1:0] txn_len;
    logic [7:0]    txn_wbyte;
    logic          txn_take = 1'b0;
    logic [7:0]    txn_rbyte = 8'h00;
    logic          txn_rvalid = 1'b0;
    logic          txn_done = 1'b0;
    logic          busy, done;
    logic [AW:0]   rsp_len;
    logic [2:0]    err_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpm_fifo_seq #(.AW(AW), .MAX_CHUNK(MAXC), .POLL_GAP(GAP), .MAX_POLLS(MPOLL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .initialized(initialized),
        .cmd_len(cmd_len), .rsp_max(rsp_max), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_we(rsp_we), .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata),
        .txn_req(txn_req), .txn_write(txn_write), .txn_fifo(txn_fifo), .txn_len(txn_len),
        .txn_wbyte(txn_wbyte), .txn_take(txn_take), .txn_rbyte(txn_rbyte),
        .txn_rvalid(txn_rvalid), .txn_done(txn_done), .busy(busy), .done(done),
        .rsp_len(rsp_len), .err_code(err_code));

    typedef struct {
        bit          wr;
        bit          fifo;
        int          len;
        logic [31:0] val;
        int          gap;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] cmd_mem [256];
    logic [7:0] cmd_cap [256];
    logic [7:0] rsp_pkt [256];
    logic [7:0] rsp_mem [256];
    int         cap_ptr = 0;
    int         rd_ptr  = 0;
    int         cyc     = 0;
    int         last_done_cyc = 0;
    int         n_checks = 0;
    int         n_fail   = 0;

    assign cmd_data = cmd_mem[cmd_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rsp_we) rsp_mem[rsp_addr] <= rsp_wdata;
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // driver side of the scoreboard
    task automatic push(bit wr, bit fifo, int len, logic [31:0] val, int gap);
        item_t it;
        it.wr = wr; it.fifo = fifo; it.len = len; it.val = val; it.gap = gap;
        exp_q.push_back(it);
    endtask

    task automatic plan_chunks(int total, bit wr, int burst, int zeros);
        int rem;
        int c;
        rem = total;
        for (int z = 0; z < zeros; z++) push(0, 0, 4, 32'h0000_0080, 0);
        while (rem > 0) begin
            push(0, 0, 4, {8'h00, 16'(burst), 8'h80}, 0);
            c = rem;
            if (burst < c) c = burst;
            if (MAXC < c) c = MAXC;
            push(wr, 1, c, 32'h0, 0);
            rem -= c;
        end
    endtask

    // monitor: acts as framer plus device, compares each access with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (txn_req) begin
                item_t       it;
                logic [31:0] wval;
                int          gap_seen;
                bit          w, f;
                int          l;
                w = txn_write; f = txn_fifo; l = int'(txn_len);
                gap_seen = cyc - last_done_cyc;
                wval = 32'h0;
                if (exp_q.size() == 0) begin
                    check(0, "R3", "unexpected transaction wr/fifo/len", {w, f, 8'(l)}, 0);
                    it.wr = w; it.fifo = f; it.len = l; it.val = 32'h0; it.gap = 0;
                end else begin
                    it = exp_q.pop_front();
                    check(w == it.wr && f == it.fifo, "R3", "transaction kind", {w, f}, {it.wr, it.fifo});
                    check(l == it.len, it.fifo ? "R5" : "R4", "transaction length", l, it.len);
                    if (it.gap > 0)
                        check(gap_seen >= it.gap, "R6", "poll spacing", gap_seen, it.gap);
                end
                for (int i = 0; i < l; i++) begin
                    if (w) begin
                        txn_take = 1'b1;
                        if (f) begin cmd_cap[cap_ptr] = txn_wbyte; cap_ptr++; end
                        else if (i < 4) wval[i*8 +: 8] = txn_wbyte;
                    end else begin
                        txn_rvalid = 1'b1;
                        if (f) begin txn_rbyte = rsp_pkt[rd_ptr]; rd_ptr++; end
                        else txn_rbyte = (i < 4) ? it.val[i*8 +: 8] : 8'h00;
                    end
                    @(negedge clk);
                    txn_take = 1'b0;
                    txn_rvalid = 1'b0;
                end
                txn_done = 1'b1;
                @(negedge clk);
                txn_done = 1'b0;
                last_done_cyc = cyc;
                if (w && !f)
                    check(wval == it.val, "R3", "status write value", wval, it.val);
            end
        end
    end

    task automatic scenario(string tag, bit init, int cmdn, int enc_delta, int rspn, int rmax,
                            int btx, int zeros, int brx, int notready, bit tmo,
                            logic [31:0] midv, logic [31:0] endv, int exp_err, bit restart);
        int enc;
        int dones;
        int wait_c;
        bit stop;
        enc = cmdn + enc_delta;
        for (int i = 0; i < 256; i++) begin
            cmd_mem[i] = 8'(i * 7 + 3);
            rsp_pkt[i] = 8'(i * 13 + 5);
            rsp_mem[i] = 8'h00;
            cmd_cap[i] = 8'h00;
        end
        cmd_mem[0] = 8'h80; cmd_mem[1] = 8'h01;
        cmd_mem[2] = 8'(enc >> 24); cmd_mem[3] = 8'(enc >> 16);
        cmd_mem[4] = 8'(enc >> 8);  cmd_mem[5] = 8'(enc);
        rsp_pkt[0] = 8'h80; rsp_pkt[1] = 8'h01;
        rsp_pkt[2] = 8'(rspn >> 24); rsp_pkt[3] = 8'(rspn >> 16);
        rsp_pkt[4] = 8'(rspn >> 8);  rsp_pkt[5] = 8'(rspn);
        cap_ptr = 0; rd_ptr = 0;
        exp_q.delete();
        stop = !init || (enc_delta != 0);
        if (!stop) begin
            push(1, 0, 4, 32'h0000_0040, 0);
            plan_chunks(cmdn, 1, btx, zeros);
            push(1, 0, 4, 32'h0000_0020, 0);
            if (tmo) begin
                for (int p = 0; p < MPOLL; p++) push(0, 0, 4, 32'h0000_0080, GAP);
                stop = 1;
            end else begin
                for (int p = 0; p < notready; p++) push(0, 0, 4, 32'h0000_0080, GAP);
                push(0, 0, 4, {8'h00, 16'(brx), 8'h90}, GAP);
                push(0, 1, 6, 32'h0, 0);
                if (rspn > rmax || rspn < 7) stop = 1;
            end
        end
        if (!stop) begin
            plan_chunks(rspn - 7, 0, brx, 0);
            push(0, 0, 4, midv, 0);
            if ((midv & 32'h90) != 32'h90) stop = 1;
        end
        if (!stop) begin
            push(0, 1, 1, 32'h0, 0);
            push(0, 0, 4, endv, 0);
            if ((endv & 32'h90) != 32'h80) stop = 1;
        end
        if (!stop) push(1, 0, 4, 32'h0000_0040, 0);

        initialized = init;
        cmd_len = (AW+1)'(cmdn);
        rsp_max = (AW+1)'(rmax);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        wait_c = 0;
        while (!done && wait_c < 20000) begin
            if (restart && wait_c == 10) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            wait_c++;
        end
        start = 1'b0;
        if (done) begin
            dones = 1;
            check(err_code == 3'(exp_err), "R10", {tag, " error code"}, err_code, exp_err);
            check(rsp_len == (exp_err == 0 ? (AW+1)'(rspn) : '0), "R10", {tag, " response length"},
                  rsp_len, (exp_err == 0 ? rspn : 0));
        end else begin
            check(0, "R10", {tag, " done never seen"}, 0, 1);
        end
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check(dones == 1, "R11", {tag, " done pulse count"}, dones, 1);
        check(exp_q.size() == 0, "R3", {tag, " expected transactions left"}, exp_q.size(), 0);
        if (exp_err == 0) begin
            int bad_c;
            int bad_r;
            bad_c = 0; bad_r = 0;
            for (int i = 0; i < cmdn; i++) if (cmd_cap[i] !== cmd_mem[i]) bad_c++;
            for (int i = 0; i < rspn; i++) if (rsp_mem[i] !== rsp_pkt[i]) bad_r++;
            check(cap_ptr == cmdn && bad_c == 0, "R5", {tag, " command bytes mismatching"}, bad_c, 0);
            check(bad_r == 0, "R8", {tag, " response bytes mismatching"}, bad_r, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R10", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !txn_req && err_code == 0 && rsp_len == 0, "R10", "reset state",
              {busy, done, txn_req, err_code}, 0);
        // R1 not initialized
        scenario("r1_noinit", 0, 20, 0, 10, 64, 64, 0, 64, 0, 0, 32'h90, 32'h80, 1, 0);
        // R2 encoded length differs
        scenario("r2_mismatch", 1, 20, 1, 10, 64, 64, 0, 64, 0, 0, 32'h90, 32'h80, 2, 0);
        // R3 R6 R11 basic run with restart pulse while busy
        scenario("r3_basic", 1, 20, 0, 10, 64, 64, 0, 64, 2, 0, 32'h90, 32'h80, 0, 1);
        // R4 R5 zero bursts, burst-limited and 64-capped chunks
        scenario("r4_r5_chunks", 1, 150, 0, 30, 200, 100, 2, 16, 0, 0, 32'h90, 32'h80, 0, 0);
        scenario("r5_small_burst", 1, 20, 0, 40, 64, 8, 1, 5, 1, 0, 32'h90, 32'h80, 0, 0);
        // R9 seven-byte response: no chunk between header and last byte
        scenario("r9_seven", 1, 12, 0, 7, 64, 64, 0, 64, 0, 0, 32'h90, 32'h80, 0, 0);
        // R6 timeout
        scenario("r6_timeout", 1, 20, 0, 10, 64, 64, 0, 64, 0, 1, 32'h90, 32'h80, 3, 0);
        // R7 response too large, then too short
        scenario("r7_toobig", 1, 20, 0, 40, 32, 64, 0, 64, 0, 0, 32'h90, 32'h80, 4, 0);
        scenario("r7_short", 1, 20, 0, 6, 64, 64, 0, 64, 0, 0, 32'h90, 32'h80, 5, 0);
        // R8 data-available missing before the last byte
        scenario("r8_midbad", 1, 20, 0, 12, 64, 64, 0, 64, 0, 0, 32'h80, 32'h80, 6, 0);
        // R9 data-available still set after the last byte
        scenario("r9_endbad", 1, 20, 0, 12, 64, 64, 0, 64, 0, 0, 32'h90, 32'h90, 7, 0);
        report();
        $finish;
    end
endmodule